// File: doc/BRIEF.md
# 8-bit Timer/Counter with Prescaler and Compare Interrupts

This block is an 8-bit up-counter driven from the system clock. A 3-bit clock-select code chooses one of several fixed divide ratios, or stops the count. The CPU uses a small register bus to read and write the count, the control code, two compare values, an interrupt mask and the pending flags.

Three events can occur: the count wraps from 255 to 0, the count reaches compare value A, or the count reaches compare value B. Each event sets its own pending flag, whether or not that event is enabled in the mask. When an enabled flag is pending, the block raises an interrupt request and presents a vector code that picks the winning source by a fixed priority. The CPU core clears a flag by acknowledging the presented vector, or by writing a 1 to that flag.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is low. The registers are count, control, compare A, compare B, mask and flags.
- R2: Register addresses are 0 count, 1 control (bits 2:0 clock select), 2 compare A, 3 compare B, 4 mask and 5 flags. Each written value reads back at its address. Unused bits read 0.
- R3: Clock-select codes 001, 010, 011, 100 and 101 divide by 1, 8, 64, 256 and 1024. Each write to the control register restarts the prescaler. With divisor N, the count has advanced by floor(k/N) after k clock edges following that write.
- R4: Codes 000, 110 and 111 stop the counter, so its value stays the same.
- R5: An increment from 255 to 0 sets the overflow flag, which is flags bit 2.
- R6: An increment that makes the count equal to compare A sets flags bit 0. One that makes it equal to compare B sets flags bit 1.
- R7: A bus write to the count register loads the written value at that edge, in place of any increment in that cycle. The count then resumes from the loaded value.
- R8: Flags are set even when their mask bit is 0 (mask bit 0 A, bit 1 B, bit 2 overflow). `irq_req` is high exactly when some flag and its mask bit are both 1.
- R9: `irq_vec` gives 0 for compare A, 1 for compare B and 2 for overflow. Compare A wins over compare B, which wins over overflow.
- R10: A cycle with `irq_ack` high while `irq_req` is high clears the flag named by `irq_vec`. Writing 1s to the flags register clears those bits, and bits written with 0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_req | output | 1 | Interrupt request toward the CPU core |
| irq_vec | output | 2 | Vector select of the winning pending source |
| irq_ack | input | 1 | Acknowledge of the presented vector |

## Verification
The count and flag path is exercised with random runs from a fixed seed. Each run picks a clock-select code, a starting count, two compare values and a run length, and the expected count and flags come from bench functions. Long runs at divide-by-1 wrap the counter several times and show whether overflow and compare detection fire on the right increments. Runs at the larger divisors show whether the prescaler gives the exact number of edges per step after its restart. Directed cases cover the three stop codes, a count write that coincides with an increment, a state where all three sources are pending under different masks to separate the priority order, and acknowledge and write-1-clear sequences that remove one flag at a time.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 10;
    localparam int SEL_W  = 3;
    localparam int NSRC   = 3;
    localparam int ADDR_W = 3;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SEL_W-1:0] sel_t;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    // register addresses
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;

    // source index doubles as bit position and vector code
    localparam int SRC_CMPA = 0;
    localparam int SRC_CMPB = 1;
    localparam int SRC_OVF  = 2;

    typedef enum logic [1:0] {
        VEC_CMPA = 2'd0,
        VEC_CMPB = 2'd1,
        VEC_OVF  = 2'd2,
        VEC_NONE = 2'd3
    } vec_e;

    typedef logic [NSRC-1:0] evt_t;

    // prescaler phase mask (divisor - 1) for a clock-select code
    function automatic logic [PRE_W-1:0] sel_mask(input sel_t s);
        case (s)
            3'd1:    return PRE_W'(0);
            3'd2:    return PRE_W'(7);
            3'd3:    return PRE_W'(63);
            3'd4:    return PRE_W'(255);
            3'd5:    return PRE_W'(1023);
            default: return PRE_W'(0);
        endcase
    endfunction

    function automatic logic sel_runs(input sel_t s);
        return (s >= 3'd1) && (s <= 3'd5);
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_t sel,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] pmask;
    logic             run;

    always_comb begin
        pmask = sel_mask(sel);
        run   = sel_runs(sel);
        tick  = run && ((phase & pmask) == pmask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R4
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  cnt_t load_val,
    input  cnt_t cmp_a,
    input  cnt_t cmp_b,
    output cnt_t count,
    output evt_t evt
);
    cnt_t nxt;
    logic step;

    always_comb begin
        step = tick && !load;
        nxt  = count + 1'b1;
        evt  = '0;
        evt[SRC_OVF]  = step && (count == CNT_MAX);
        evt[SRC_CMPA] = step && (nxt == cmp_a);
        evt[SRC_CMPB] = step && (nxt == cmp_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= nxt;
        end
    end

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && tick) |=> (count == cnt_t'($past(count) + 1'b1)));
endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  evt_t mask,
    input  evt_t w1c,
    input  logic ack,
    output evt_t flags,
    output logic irq_req,
    output vec_e irq_vec
);
    evt_t live;
    evt_t ack_clr;

    always_comb begin
        live    = flags & mask;
        irq_req = |live;
        if (live[SRC_CMPA])      irq_vec = VEC_CMPA;
        else if (live[SRC_CMPB]) irq_vec = VEC_CMPB;
        else if (live[SRC_OVF])  irq_vec = VEC_OVF;
        else                     irq_vec = VEC_NONE;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        assign ack_clr[i] = ack && irq_req && (irq_vec == vec_e'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (evt[i]) begin
                flags[i] <= 1'b1;
            end else if (w1c[i] || ack_clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & mask) == '0) |-> !irq_req);

    // R9
    prio_a_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[SRC_CMPA] && mask[SRC_CMPA]) |-> (irq_vec == VEC_CMPA));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt[SRC_OVF] |=> flags[SRC_OVF]);
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
    import tmr8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_req,
    output logic [1:0]        irq_vec,
    input  logic              irq_ack
);
    sel_t ctrl_sel;
    cnt_t cmp_a, cmp_b, count;
    evt_t mask, flags, evt, w1c;
    logic tick;
    logic wr_count, wr_ctrl;
    vec_e vec;

    assign wr_count = bus_wr && (bus_addr == A_COUNT);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign w1c      = (bus_wr && (bus_addr == A_FLAGS)) ? bus_wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_sel <= '0;
            cmp_a    <= '0;
            cmp_b    <= '0;
            mask     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_sel <= bus_wdata[SEL_W-1:0];
                A_CMPA:  cmp_a    <= bus_wdata;
                A_CMPB:  cmp_b    <= bus_wdata;
                A_MASK:  mask     <= bus_wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    tmr8_prescale i_pre (
        .clk     (clk),
        .rst     (rst),
        .sel     (ctrl_sel),
        .restart (wr_ctrl),
        .tick    (tick)
    );

    tmr8_count i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_count),
        .load_val (bus_wdata),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .count    (count),
        .evt      (evt)
    );

    tmr8_irq i_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .mask    (mask),
        .w1c     (w1c),
        .ack     (irq_ack),
        .flags   (flags),
        .irq_req (irq_req),
        .irq_vec (vec)
    );

    assign irq_vec = vec;

    always_comb begin
        case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_CTRL:  bus_rdata = {{(8-SEL_W){1'b0}}, ctrl_sel};
            A_CMPA:  bus_rdata = cmp_a;
            A_CMPB:  bus_rdata = cmp_b;
            A_MASK:  bus_rdata = {{(8-NSRC){1'b0}}, mask};
            A_FLAGS: bus_rdata = {{(8-NSRC){1'b0}}, flags};
            default: bus_rdata = '0;
        endcase
    end

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_runs(ctrl_sel) && !wr_count) |=> $stable(count));

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && vec == VEC_OVF && !evt[SRC_OVF]) |=> !flags[SRC_OVF]);
endmodule

// File: tb/test_tmr8_unit.sv
module test_tmr8_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic [1:0] irq_vec;
    logic       irq_ack = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmr8_unit i_tmr8_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    function automatic int div_of(input int sel);
        case (sel)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cnt(input int init, input int inc);
        return (init + inc) % 256;
    endfunction

    function automatic int exp_flags(input int init, input int inc, input int ca, input int cb);
        int f = 0;
        for (int j = 1; j <= inc; j++) begin
            int v = (init + j) % 256;
            if (v == ca) f |= 1;
            if (v == cb) f |= 2;
            if (v == 0)  f |= 4;
        end
        return f;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = 8'(d);
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 3'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic ack;
        @(negedge clk);
        irq_ack = 1'b1;
        @(posedge clk);
        #1;
        irq_ack = 1'b0;
        #1;
    endtask

    // start a run: stop, clear flags, load count and compares, then select
    task automatic run(input int sel, input int init, input int ca, input int cb, input int k);
        wr(1, 0);
        wr(5, 7);
        wr(2, ca);
        wr(3, cb);
        wr(0, init);
        wr(1, sel);
        repeat (k) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int d, f, sel, init, ca, cb, k, inc;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R1 reset register", d, 0);
        end
        check("R1 irq_req", int'(irq_req), 0);

        // R2 register readback
        wr(2, 8'hA5); wr(3, 8'h3C); wr(4, 8'hFF); wr(1, 8'hFA);
        #1;
        rd(2, d); check("R2 cmpA readback", d, 8'hA5);
        rd(3, d); check("R2 cmpB readback", d, 8'h3C);
        rd(4, d); check("R2 mask readback", d, 7);
        rd(1, d); check("R2 ctrl readback", d, 2);
        wr(1, 0); wr(4, 0);

        // R3 R5 R6 random runs
        for (int it = 0; it < 24; it++) begin
            sel  = $urandom_range(1, 5);
            init = $urandom_range(0, 255);
            ca   = $urandom_range(0, 255);
            cb   = $urandom_range(0, 255);
            k    = $urandom_range(0, 2600);
            run(sel, init, ca, cb, k);
            inc = k / div_of(sel);
            rd(0, d); check("R3 count after run", d, exp_cnt(init, inc));
            rd(5, f); check("R5 R6 flags after run", f, exp_flags(init, inc, ca, cb));
        end

        // R3 exact prescaler boundary at divide-by-8
        run(2, 10, 0, 0, 7);
        rd(0, d); check("R3 div8 before step", d, 10);
        run(2, 10, 0, 0, 8);
        rd(0, d); check("R3 div8 at step", d, 11);

        // R4 stop codes
        for (int s = 0; s < 8; s++) begin
            if (s == 0 || s == 6 || s == 7) begin
                run(s, 77, 78, 79, 300);
                rd(0, d); check("R4 stopped count", d, 77);
                rd(5, f); check("R4 no flags when stopped", f, 0);
            end
        end

        // R5 wrap
        run(1, 255, 5, 5, 1);
        rd(0, d); check("R5 wrap count", d, 0);
        rd(5, f); check("R5 ovf flag", f, 4);

        // R7 load priority while running at div 1
        run(1, 0, 200, 200, 5);
        wr(0, 8'h80);
        #1;
        rd(0, d); check("R7 loaded value", d, 8'h80);
        @(posedge clk); #2;
        rd(0, d); check("R7 resumes after load", d, 8'h81);

        // R8 R9 R10 priority, mask, acknowledge
        run(1, 254, 255, 0, 2);
        wr(1, 0);
        #1;
        rd(5, f); check("R8 flags set while masked", f, 7);
        check("R8 masked no request", int'(irq_req), 0);
        wr(4, 4); #1;
        check("R8 ovf-only request", int'(irq_req), 1);
        check("R9 ovf vector", int'(irq_vec), 2);
        wr(4, 7); #1;
        check("R9 A first", int'(irq_vec), 0);
        ack;
        check("R10 after ack A", int'(irq_vec), 1);
        rd(5, f); check("R10 flags after ack A", f, 6);
        ack;
        check("R10 after ack B", int'(irq_vec), 2);
        ack;
        check("R10 all acked", int'(irq_req), 0);

        // R10 write-1-clear keeps zero bits
        run(1, 254, 255, 0, 2);
        wr(1, 0);
        wr(5, 2); #1;
        rd(5, f); check("R10 w1c B only", f, 5);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule